// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a wide vector of general-purpose pins, split into banks of 32, and records level transitions on the pins that are configured as inputs. Each bank holds a rising-enable mask, a falling-enable mask and a sticky status word. A detected, enabled edge sets the matching status bit. The bit stays set until software writes a one to that bit position. The pins are sampled synchronously: any synchroniser sits outside the unit, and the previous sample of every pin is kept in a register so that edges are found by comparing consecutive samples.

The status words drive three registered interrupt lines. Pin 0 and pin 1 each have their own line, and every other pin shares a third line. Each bank also has a fixed wake-source bitmap. While the core reports that it is halted, a level change on any input pin that appears in that bitmap produces a one-cycle wake pulse. A simple synchronous register bus gives access to the enables and the status words. Pins with an index at or above the configured pin count never record anything.

Top module: `gpio_edge_irq`

## Requirements
- R1: A low-to-high change between two consecutive samples of an input pin (direction bit 0) sets that pin's status bit at the clock edge where the new level is sampled, when its rising-enable bit is 1. When its rising-enable bit is 0 the status bit is unaffected.
- R2: A high-to-low change of an input pin sets its status bit at that edge when its falling-enable bit is 1.
- R3: Pins whose direction bit is 1 (output) never set a status bit and never cause a wake pulse.
- R4: Status is sticky. A bus write to a status word clears every bit written as 1 and leaves the bits written as 0 unchanged. A read returns the current status.
- R5: If an edge sets a status bit in the same cycle as a write clears it, the bit ends up set.
- R6: irq_pin0_o equals bank-0 status bit 0, and irq_pin1_o equals bank-0 status bit 1, each one clock cycle later.
- R7: irq_shared_o, one cycle later, is the OR of bank-0 status bits 31:2 and every status bit of the other banks.
- R8: wake_pulse_o is high for one cycle after an edge where halted_i is 1 and some input pin that is set in its bank's wake mask changed level. The wake masks for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R9: Pins with global index at or above NUM_PINS (default 120) are ignored: their status never sets, they never wake, and their enable bits read back 0.
- R10: Word offsets are: rising-enable at 0x030, 0x034, 0x038 and 0x130; falling-enable at 0x03C, 0x040, 0x044 and 0x13C; status at 0x048, 0x04C, 0x050 and 0x148, for banks 0..3. Enables read back what was written. Any other offset reads 0.
- R11: After reset all enables, status words, interrupt lines and the wake pulse are 0. The first sample after reset is not compared against anything, so a pin that is already high does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | 128 | Synchronised pin levels, bit n = pin n |
| pin_dir_i | input | 128 | Pin direction, 1 = output, 0 = input |
| halted_i | input | 1 | Core halted; enables wake pulses |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_shared_o | output | 1 | Interrupt for all other pins |
| wake_pulse_o | output | 1 | One-cycle wake request |

## Verification
The situation that is hardest to reach is a set-versus-clear collision. The bench moves a pin in the same half-cycle in which it places a status-clear write on the bus, so that the edge and the clear land on one clock edge. It also holds a pin high through reset, to show that the first sample is not treated as an edge. Every pin index, including the ignored ones above the pin count, is swept through a rising and a falling edge while the core is halted. In that sweep the bench predicts the status word, the routing of the three interrupt lines and the wake bitmap arithmetically.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam logic [15:0] RISE_BASE = 16'h030;
  localparam logic [15:0] FALL_BASE = 16'h03C;
  localparam logic [15:0] STAT_BASE = 16'h048;
  localparam logic [15:0] HIGH_OFS  = 16'h100;
  localparam int          HIGH_FIRST = 3;

  // Byte offset of a per-bank register; banks from HIGH_FIRST on sit in the upper window
  function automatic logic [15:0] reg_offset(logic [15:0] base, int bank);
    if (bank >= HIGH_FIRST)
      return base + HIGH_OFS + 16'(4 * (bank - HIGH_FIRST));
    return base + 16'(4 * bank);
  endfunction

  // Fixed map of pins allowed to wake the halted core
  function automatic logic [63:0] wake_source_mask(int bank);
    case (bank)
      0:       return 64'h0000_0000_8003_FE1B;
      1:       return 64'h0000_0000_0020_01FC;
      2:       return 64'h0000_0000_EC08_0000;
      3:       return 64'h0000_0000_0012_007F;
      default: return 64'h0;
    endcase
  endfunction

  // Bits of a bank whose global pin index is below the pin count
  function automatic logic [63:0] pin_valid_mask(int bank, int width, int npins);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < width && i < 64; i++)
      m[i] = ((bank * width + i) < npins);
    return m;
  endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int               W     = 32,
  parameter logic [W-1:0]     VALID = '1,
  parameter logic [W-1:0]     WAKE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prime_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] stat_o,
  output logic         wake_hit_o
);

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] rise_q, rise_d;
  logic [W-1:0] fall_q, fall_d;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] in_pins, up_edge, dn_edge, set_bits, clr_bits;

  always_comb begin
    in_pins  = ~dir_i & VALID & {W{prime_i}};
    up_edge  = lvl_i & ~prev_q & in_pins;
    dn_edge  = ~lvl_i & prev_q & in_pins;
    set_bits = (up_edge & rise_q) | (dn_edge & fall_q);
    clr_bits = wr_clr_i ? wdata_i : '0;
    // set has priority over a simultaneous clear
    stat_d   = (stat_q & ~clr_bits) | set_bits;
    rise_d   = wr_rise_i ? (wdata_i & VALID) : rise_q;
    fall_d   = wr_fall_i ? (wdata_i & VALID) : fall_q;
    prev_d   = lvl_i & VALID;
    wake_hit_o = |((up_edge | dn_edge) & WAKE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= prev_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      stat_q <= stat_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign stat_o = stat_q;

  // newly set status bits only ever belong to pins that were inputs
  assert_set_only_inputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & $past(dir_i)) == '0));

  // a bit can only drop through a clear write
  assert_drop_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q)) != '0) |-> $past(wr_clr_i));

  // cleared bits without a concurrent edge are zero afterwards
  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_i |=> ((stat_q & $past(wdata_i) & ~$past(set_bits)) == '0));

  // edge wins over a clear aimed at the same bit
  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_bits & clr_bits) != '0) |=> (($past(set_bits & clr_bits) & ~stat_q) == '0));

endmodule

// File: rtl/gpio_edge_irqout.sv
module gpio_edge_irqout #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic         wake_any_i,
  input  logic         halted_i,
  output logic         irq0_o,
  output logic         irq1_o,
  output logic         irqx_o,
  output logic         wake_o
);

  logic irq0_d, irq1_d, irqx_d, wake_d;

  always_comb begin
    irq0_d = stat_i[0];
    irq1_d = stat_i[1];
    irqx_d = |stat_i[N-1:2];
    wake_d = halted_i & wake_any_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
      irqx_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq0_o <= irq0_d;
      irq1_o <= irq1_d;
      irqx_o <= irqx_d;
      wake_o <= wake_d;
    end
  end

  assert_pin1_lags_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_i[1]) |=> irq1_o);

  assert_wake_needs_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(halted_i));

  assert_shared_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqx_o |-> ($past(stat_i) & ~{{(N-2){1'b0}}, 2'b11}) != '0);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int NUM_PINS  = 120,
  parameter int ADDR_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_level_i,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_dir_i,
  input  logic                        halted_i,
  input  logic                        bus_en_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BANK_W-1:0]           bus_wdata_i,
  output logic [BANK_W-1:0]           bus_rdata_o,
  output logic                        irq_pin0_o,
  output logic                        irq_pin1_o,
  output logic                        irq_shared_o,
  output logic                        wake_pulse_o
);

  localparam int PIN_W = NUM_BANKS * BANK_W;

  logic                  prime_q, prime_d;
  logic [NUM_BANKS-1:0]  wr_rise, wr_fall, wr_clr, wake_hit;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rise_all, fall_all, stat_all;
  logic [PIN_W-1:0]      stat_flat;
  logic                  rd_en;

  // first sample after reset only loads the history
  assign prime_d = 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prime_q <= 1'b0;
    else        prime_q <= prime_d;
  end

  always_comb begin
    rd_en       = bus_en_i & ~bus_we_i;
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      wr_rise[b] = bus_en_i & bus_we_i & (bus_addr_i == ADDR_W'(reg_offset(RISE_BASE, b)));
      wr_fall[b] = bus_en_i & bus_we_i & (bus_addr_i == ADDR_W'(reg_offset(FALL_BASE, b)));
      wr_clr[b]  = bus_en_i & bus_we_i & (bus_addr_i == ADDR_W'(reg_offset(STAT_BASE, b)));
      if (rd_en && bus_addr_i == ADDR_W'(reg_offset(RISE_BASE, b))) bus_rdata_o = rise_all[b];
      if (rd_en && bus_addr_i == ADDR_W'(reg_offset(FALL_BASE, b))) bus_rdata_o = fall_all[b];
      if (rd_en && bus_addr_i == ADDR_W'(reg_offset(STAT_BASE, b))) bus_rdata_o = stat_all[b];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] VMASK = BANK_W'(pin_valid_mask(b, BANK_W, NUM_PINS));
    localparam logic [BANK_W-1:0] WMASK = BANK_W'(wake_source_mask(b));
    gpio_edge_bank #(.W(BANK_W), .VALID(VMASK), .WAKE(WMASK)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .prime_i    (prime_q),
      .lvl_i      (pin_level_i[b*BANK_W +: BANK_W]),
      .dir_i      (pin_dir_i[b*BANK_W +: BANK_W]),
      .wr_rise_i  (wr_rise[b]),
      .wr_fall_i  (wr_fall[b]),
      .wr_clr_i   (wr_clr[b]),
      .wdata_i    (bus_wdata_i),
      .rise_o     (rise_all[b]),
      .fall_o     (fall_all[b]),
      .stat_o     (stat_all[b]),
      .wake_hit_o (wake_hit[b])
    );
  end

  assign stat_flat = stat_all;

  gpio_edge_irqout #(.N(PIN_W)) i_irqout (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_i     (stat_flat),
    .wake_any_i (|wake_hit),
    .halted_i   (halted_i),
    .irq0_o     (irq_pin0_o),
    .irq1_o     (irq_pin1_o),
    .irqx_o     (irq_shared_o),
    .wake_o     (wake_pulse_o)
  );

  // the pulse never lasts two cycles while inputs are quiet
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse_o && $stable(pin_level_i)) |=> !wake_pulse_o);

endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam int NP = 120;
  localparam int TOT = NB * W;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [TOT-1:0] pin_level, pin_dir;
  logic           halted, bus_en, bus_we;
  logic [8:0]     bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic           irq0, irq1, irqx, wake;
  int             errs = 0, checks = 0;
  logic [31:0]    rv;
  bit             done = 0;

  always #2 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_level_i(pin_level), .pin_dir_i(pin_dir),
    .halted_i(halted), .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_pin0_o(irq0),
    .irq_pin1_o(irq1), .irq_shared_o(irqx), .wake_pulse_o(wake)
  );

  function automatic logic [8:0] offs(int kind, int b);
    logic [8:0] base;
    base = (kind == 0) ? 9'h030 : (kind == 1) ? 9'h03C : 9'h048;
    return (b == 3) ? base + 9'h100 : base + 9'(4 * b);
  endfunction

  function automatic bit wake_bit(int p);
    logic [31:0] m [4] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};
    return m[p / 32][p % 32];
  endfunction

  function automatic logic [31:0] valid_word(int b);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = (b * 32 + i) < NP;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_level = '0; pin_dir = '0; halted = 1;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    pin_level[3] = 1'b1;                       // high through reset (R11)
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 wake after reset", {31'b0, wake}, 0);
    chk("R11 irqs after reset", {29'b0, irq0, irq1, irqx}, 0);
    for (int b = 0; b < NB; b++) begin
      rd(offs(2, b), rv); chk("R11 status reset", rv, 0);
      rd(offs(0, b), rv); chk("R11 rise enable reset", rv, 0);
    end
    @(negedge clk);
    chk("R11 no edge from first sample", {31'b0, wake}, 0);
    pin_level[3] = 1'b0;                       // wake-mask pin, halted
    @(negedge clk);
    chk("R8 wake on fall of mask pin", {31'b0, wake}, 1);
    @(negedge clk);
    chk("R8 wake is one cycle", {31'b0, wake}, 0);

    for (int b = 0; b < NB; b++) begin
      wr(offs(0, b), 32'hFFFF_FFFF);
      wr(offs(1, b), 32'hFFFF_FFFF);
      rd(offs(0, b), rv); chk("R10 R9 rise enable readback", rv, valid_word(b));
      rd(offs(1, b), rv); chk("R10 R9 fall enable readback", rv, valid_word(b));
    end

    // sweep every pin through a rising and a falling edge
    for (int p = 0; p < TOT; p++) begin
      int          b;
      logic [31:0] m;
      bit          v;
      b = p / 32; m = 32'h1 << (p % 32); v = (p < NP);
      pin_level[p] = 1'b1;
      @(negedge clk);
      chk("R8 wake on rise", {31'b0, wake}, {31'b0, v & wake_bit(p)});
      rd(offs(2, b), rv); chk("R1 R9 status on rise", rv, v ? m : 32'h0);
      @(negedge clk);
      chk("R6 irq pin0", {31'b0, irq0}, {31'b0, p == 0});
      chk("R6 irq pin1", {31'b0, irq1}, {31'b0, p == 1});
      chk("R7 shared irq", {31'b0, irqx}, {31'b0, v && p >= 2});
      chk("R8 pulse ends", {31'b0, wake}, 0);
      wr(offs(2, b), m);
      rd(offs(2, b), rv); chk("R4 write-one clears", rv, 0);
      pin_level[p] = 1'b0;
      @(negedge clk);
      chk("R8 wake on fall", {31'b0, wake}, {31'b0, v & wake_bit(p)});
      rd(offs(2, b), rv); chk("R2 status on fall", rv, v ? m : 32'h0);
      wr(offs(2, b), m);
    end

    // output-direction pins are ignored
    pin_dir = '1;
    pin_level[5] = 1'b1; pin_level[40] = 1'b1;
    @(negedge clk);
    chk("R3 no wake from outputs", {31'b0, wake}, 0);
    rd(offs(2, 0), rv); chk("R3 bank0 status", rv, 0);
    rd(offs(2, 1), rv); chk("R3 bank1 status", rv, 0);
    pin_level[5] = 1'b0; pin_level[40] = 1'b0;
    @(negedge clk);
    rd(offs(2, 0), rv); chk("R3 bank0 after fall", rv, 0);
    pin_dir = '0;
    @(negedge clk);

    // clear with zeros keeps bits
    pin_level[10] = 1'b1; pin_level[12] = 1'b1;
    @(negedge clk);
    wr(offs(2, 0), 32'h1 << 10);
    rd(offs(2, 0), rv); chk("R4 other bit kept", rv, 32'h1 << 12);
    wr(offs(2, 0), 32'h0);
    rd(offs(2, 0), rv); chk("R4 zero write no effect", rv, 32'h1 << 12);
    pin_level[10] = 1'b0; pin_level[12] = 1'b0;
    @(negedge clk);
    wr(offs(2, 0), 32'hFFFF_FFFF);

    // edge and clear on the same clock edge
    pin_level[3] = 1'b1;
    wr(offs(2, 0), 32'h1 << 3);
    rd(offs(2, 0), rv); chk("R5 set beats clear", rv, 32'h1 << 3);
    pin_level[3] = 1'b0;
    @(negedge clk);
    wr(offs(2, 0), 32'hFFFF_FFFF);

    // rising enable off
    wr(offs(0, 1), 32'h0);
    pin_level[33] = 1'b1;
    @(negedge clk);
    rd(offs(2, 1), rv); chk("R1 disabled rise ignored", rv, 0);

    // not halted: no wake
    halted = 1'b0;
    pin_level[34] = 1'b1;
    @(negedge clk);
    chk("R8 no wake when running", {31'b0, wake}, 0);
    halted = 1'b1;

    rd(9'h000, rv); chk("R10 unmapped read", rv, 0);
    rd(9'h13C, rv); chk("R10 bank3 fall offset", rv, 32'h00FF_FFFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule